// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block raises and clears message-passing interrupts between two processors that share one memory through a left port and a right port. It does not hold the message. The message is kept in the shared array. The block watches each port's enable, write strobe, address and busy input. It keeps one pending flag per port and drives that flag out as an active-low interrupt.

Two addresses at the top of the address space act as doorbells:
- The all-ones address is the right port's mailbox.
- The address one below it is the left port's mailbox.

When a port writes the other port's mailbox, the owner of that mailbox gets an interrupt. When the owner later reads its own mailbox, the interrupt is cleared. An active busy input on a port stops that port's accesses from setting or clearing any flag. The address width is a parameter. A second parameter chooses whether a simultaneous set and clear of one flag leaves it set (the default) or clear.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), both l_irq_n and r_irq_n are 1 (inactive).
- R2: A left access with l_cs=1, l_we=1, l_busy=0 and l_addr equal to all ones drives r_irq_n to 0 from the next rising clock edge.
- R3: A right access with r_cs=1, r_we=1, r_busy=0 and r_addr equal to all ones minus one drives l_irq_n to 0 from the next rising clock edge.
- R4: A port reading its own mailbox with cs=1, we=0 and busy=0 returns its own interrupt to 1 at the next edge. The right port's mailbox is all ones and the left port's mailbox is all ones minus one.
- R5: A port reading the other port's mailbox leaves both interrupt outputs unchanged.
- R6: While a port's busy input is 1, its write to the other port's mailbox does not assert the other port's interrupt.
- R7: While a port's busy input is 1, its read of its own mailbox does not clear its own interrupt.
- R8: With the default SET_WINS=1, a set and a clear of the same flag at the same edge leave that interrupt at 0.
- R9: These accesses change no interrupt output:
  - any access with cs=0;
  - a write by a port to its own mailbox;
  - any access to an address other than the two mailboxes.
- R10: With no setting or clearing access, both interrupt outputs hold their value from edge to edge. No output reacts to an input before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; accesses are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs | input | 1 | Left port access enable, active high |
| l_we | input | 1 | Left port direction: 1 write, 0 read |
| l_addr | input | ADDR_W | Left port address |
| l_busy | input | 1 | Left port busy, active high; blocks the left port's mailbox effects |
| r_cs | input | 1 | Right port access enable, active high |
| r_we | input | 1 | Right port direction: 1 write, 0 read |
| r_addr | input | ADDR_W | Right port address |
| r_busy | input | 1 | Right port busy, active high; blocks the right port's mailbox effects |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Every set and clear is registered. A mailbox access presented before a rising edge shows on the interrupt outputs just after that edge and not before. Reset is the exception: it acts at once, without waiting for a clock edge.

The bench drives each stimulus on a falling edge and lets one rising edge pass. It then compares both outputs on the following falling edge. One directed test also samples between the drive and the edge to confirm nothing reacts early. Another samples just after reset is asserted in mid-cycle to confirm the asynchronous clear.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

   typedef enum logic {
      SIDE_LEFT  = 1'b0,
      SIDE_RIGHT = 1'b1
   } side_e;

   localparam int MIN_ADDR_W = 2;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
   import mbox_irq_pkg::*;
#(
   parameter int    ADDR_W = 14,
   parameter side_e SIDE   = SIDE_LEFT
) (
   input  logic              cs,
   input  logic              we,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   output logic              peer_set,
   output logic              own_clr
);

   localparam logic [ADDR_W-1:0] TOP_ADDR   = '1;
   localparam logic [ADDR_W-1:0] BELOW_ADDR = TOP_ADDR - 1'b1;
   localparam logic [ADDR_W-1:0] OWN_ADDR   = (SIDE == SIDE_RIGHT) ? TOP_ADDR : BELOW_ADDR;
   localparam logic [ADDR_W-1:0] PEER_ADDR  = (SIDE == SIDE_RIGHT) ? BELOW_ADDR : TOP_ADDR;

   logic live;

   assign live     = cs & ~busy;
   assign peer_set = live &  we & (addr == PEER_ADDR);
   assign own_clr  = live & ~we & (addr == OWN_ADDR);

endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);

   logic pend_q;
   logic pend_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb pend_d = set | (pend_q & ~clr);
      end else begin : g_clr_first
         always_comb pend_d = ~clr & (pend_q | set);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   assign irq_n = ~pend_q;

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
   import mbox_irq_pkg::*;
#(
   parameter int ADDR_W   = 14,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_cs,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_busy,
   input  logic              r_cs,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_busy,
   output logic              l_irq_n,
   output logic              r_irq_n
);

   localparam int NSIDE = 2;

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_width
         $error("mbox_irq_ctrl: ADDR_W must be at least %0d", MIN_ADDR_W);
      end
   endgenerate

   logic [NSIDE-1:0]  cs_v;
   logic [NSIDE-1:0]  we_v;
   logic [NSIDE-1:0]  busy_v;
   logic [ADDR_W-1:0] addr_v [NSIDE];
   logic [NSIDE-1:0]  peer_set_v;
   logic [NSIDE-1:0]  own_clr_v;
   logic [NSIDE-1:0]  irq_n_v;

   assign cs_v      = {r_cs, l_cs};
   assign we_v      = {r_we, l_we};
   assign busy_v    = {r_busy, l_busy};
   assign addr_v[0] = l_addr;
   assign addr_v[1] = r_addr;

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         mbox_port_decode #(
            .ADDR_W (ADDR_W),
            .SIDE   ((s == 0) ? SIDE_LEFT : SIDE_RIGHT)
         ) u_dec (
            .cs       (cs_v[s]),
            .we       (we_v[s]),
            .busy     (busy_v[s]),
            .addr     (addr_v[s]),
            .peer_set (peer_set_v[s]),
            .own_clr  (own_clr_v[s])
         );

         mbox_irq_flag #(
            .SET_WINS (SET_WINS)
         ) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (peer_set_v[NSIDE-1-s]),
            .clr   (own_clr_v[s]),
            .irq_n (irq_n_v[s])
         );
      end
   endgenerate

   assign l_irq_n = irq_n_v[0];
   assign r_irq_n = irq_n_v[1];

endmodule

// File: rtl/mbox_irq_ctrl_chk.sv
module mbox_irq_ctrl_chk #(
   parameter int ADDR_W   = 14,
   parameter bit SET_WINS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_cs,
   input logic              l_we,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_busy,
   input logic              r_cs,
   input logic              r_we,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_busy,
   input logic              l_irq_n,
   input logic              r_irq_n
);

   localparam logic [ADDR_W-1:0] HI_ADDR = '1;
   localparam logic [ADDR_W-1:0] LO_ADDR = HI_ADDR - 1'b1;

   logic ring_right, ack_right, ring_left, ack_left;

   assign ring_right = l_cs &  l_we & ~l_busy & (l_addr == HI_ADDR);
   assign ack_right  = r_cs & ~r_we & ~r_busy & (r_addr == HI_ADDR);
   assign ring_left  = r_cs &  r_we & ~r_busy & (r_addr == LO_ADDR);
   assign ack_left   = l_cs & ~l_we & ~l_busy & (l_addr == LO_ADDR);

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (l_irq_n && r_irq_n));

   assert_ring_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_right && !(!SET_WINS && ack_right)) |=> !r_irq_n);

   assert_ring_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_left && !(!SET_WINS && ack_left)) |=> !l_irq_n);

   assert_ack_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_right && !(SET_WINS && ring_right)) |=> r_irq_n);

   assert_ack_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_left && !(SET_WINS && ring_left)) |=> l_irq_n);

   assert_hold_right_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ring_right && !ack_right) |=> $stable(r_irq_n));

   assert_hold_left_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ring_left && !ack_left) |=> $stable(l_irq_n));

endmodule

bind mbox_irq_ctrl mbox_irq_ctrl_chk #(
   .ADDR_W   (ADDR_W),
   .SET_WINS (SET_WINS)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .l_cs    (l_cs),
   .l_we    (l_we),
   .l_addr  (l_addr),
   .l_busy  (l_busy),
   .r_cs    (r_cs),
   .r_we    (r_we),
   .r_addr  (r_addr),
   .r_busy  (r_busy),
   .l_irq_n (l_irq_n),
   .r_irq_n (r_irq_n)
);

// File: tb/mbox_irq_ctrl_tb.sv
module mbox_irq_ctrl_tb;

   localparam int AW = 14;
   localparam logic [AW-1:0] A_HI = '1;
   localparam logic [AW-1:0] A_LO = A_HI - 1'b1;
   localparam int NV = 18;

   // {l_cs,l_we,l_busy,l_sel[1:0], r_cs,r_we,r_busy,r_sel[1:0], exp_l_n, exp_r_n}
   // sel: 0 -> address 5, 1 -> left mailbox, 2 -> right mailbox, 3 -> address 0
   localparam logic [11:0] VEC [NV] = '{
      12'b1_1_0_10_0_0_0_00_1_0,  // 0  R2 left rings right
      12'b0_0_0_00_1_0_0_01_1_0,  // 1  R5 right reads left box
      12'b0_0_0_00_1_0_1_10_1_0,  // 2  R7 right ack while busy
      12'b0_0_0_00_1_0_0_10_1_1,  // 3  R4 right ack
      12'b0_0_0_00_1_1_1_01_1_1,  // 4  R6 right ring while busy
      12'b0_0_0_00_1_1_0_01_0_1,  // 5  R3 right rings left
      12'b1_0_0_10_0_0_0_00_0_1,  // 6  R5 left reads right box
      12'b0_0_0_01_0_0_0_00_0_1,  // 7  R9 cs low
      12'b1_0_1_01_0_0_0_00_0_1,  // 8  R7 left ack while busy
      12'b1_0_0_01_1_1_0_01_0_1,  // 9  R8 left ack with right ring
      12'b1_0_0_01_0_0_0_00_1_1,  // 10 R4 left ack
      12'b1_1_0_01_0_0_0_00_1_1,  // 11 R9 left writes own box
      12'b1_1_0_00_0_0_0_00_1_1,  // 12 R9 other address
      12'b1_1_1_10_0_0_0_00_1_1,  // 13 R6 left ring while busy
      12'b1_1_0_10_1_0_0_10_1_0,  // 14 R8 ring right with right ack
      12'b0_0_0_00_1_1_0_10_1_0,  // 15 R9 right writes own box
      12'b0_0_0_00_1_1_0_11_1_0,  // 16 R9 address zero
      12'b0_0_0_00_1_0_0_10_1_1   // 17 R4 right ack
   };

   function automatic string vec_tag(int i);
      case (i)
         0:             return "R2";
         1, 6:          return "R5";
         2, 8:          return "R7";
         3, 10, 17:     return "R4";
         4, 13:         return "R6";
         5:             return "R3";
         9, 14:         return "R8";
         default:       return "R9";
      endcase
   endfunction

   function automatic logic [AW-1:0] sel_addr(logic [1:0] s);
      case (s)
         2'd0:    return AW'(5);
         2'd1:    return A_LO;
         2'd2:    return A_HI;
         default: return '0;
      endcase
   endfunction

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_cs = 1'b0, l_we = 1'b0, l_busy = 1'b0;
   logic r_cs = 1'b0, r_we = 1'b0, r_busy = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_irq_n, r_irq_n;
   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   mbox_irq_ctrl #(.ADDR_W(AW)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .l_cs (l_cs), .l_we (l_we), .l_addr (l_addr), .l_busy (l_busy),
      .r_cs (r_cs), .r_we (r_we), .r_addr (r_addr), .r_busy (r_busy),
      .l_irq_n (l_irq_n), .r_irq_n (r_irq_n)
   );

   task automatic chk(string tag, logic [1:0] exp);
      n_chk++;
      if ({l_irq_n, r_irq_n} !== exp) begin
         n_bad++;
         $display("FAIL %s {l_irq_n,r_irq_n} actual=%b expected=%b", tag, {l_irq_n, r_irq_n}, exp);
      end
   endtask

   task automatic idle();
      l_cs = 0; l_we = 0; l_busy = 0; l_addr = '0;
      r_cs = 0; r_we = 0; r_busy = 0; r_addr = '0;
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", 2'b11);  // R1 held in reset
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 2'b11);

      for (int i = 0; i < NV; i++) begin
         l_cs = VEC[i][11]; l_we = VEC[i][10]; l_busy = VEC[i][9]; l_addr = sel_addr(VEC[i][8:7]);
         r_cs = VEC[i][6];  r_we = VEC[i][5];  r_busy = VEC[i][4]; r_addr = sel_addr(VEC[i][3:2]);
         @(posedge clk);
         @(negedge clk);
         chk(vec_tag(i), VEC[i][1:0]);
      end

      // R10: no reaction before the edge; R2 after it
      l_cs = 1; l_we = 1; l_addr = A_HI;
      #2;
      chk("R10", 2'b11);
      @(posedge clk);
      @(negedge clk);
      chk("R2", 2'b10);

      // R9: right ack with cs low does nothing
      idle();
      r_we = 0; r_addr = A_HI;
      @(posedge clk);
      @(negedge clk);
      chk("R9", 2'b10);

      // R3 together with R2 hold: ring left
      idle();
      r_cs = 1; r_we = 1; r_addr = A_LO;
      @(posedge clk);
      @(negedge clk);
      chk("R3", 2'b00);

      // R10 idle cycles hold
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", 2'b00);

      // R1: asynchronous reset mid-cycle
      #2;
      rst_n = 1'b0;
      #1;
      chk("R1", 2'b11);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 2'b11);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule